// File: doc/BRIEF.md
# Display Cursor Register Bank

This block holds the programmable state of a hardware display cursor: enable, blend mode, magnify and clamp flags, screen position, hotspot, size, two colours and the base byte address of the cursor surface. A host writes these values through a simple word-addressed write/read port into a pending (shadow) set. The cursor engine only sees a second, active set. That set is refreshed from the pending set, all fields in the same clock edge, when a frame-start pulse arrives and the update lock is clear.

The lock lets software change several registers without the engine seeing a mix of old and new values in the middle of a frame. The 40-bit surface address is split across two registers. The upper byte is staged first, and the whole address becomes pending only when the low word is written. Reads always return the pending values.

Top module: `cursor_regbank`

## Requirements
- R1: After reset every register reads 0 and the active outputs are cleared: cursor disabled, mode 0, position, hotspot and address 0. Both size outputs are 1, and the colour outputs are 0x000000 and 0xFFFFFF.
- R2: Register offsets, field positions and readback:
  - 0: lock in bit 0.
  - 1: control. Enable in bit 0, mode in bits 2:1 (0 mono, 1 colour with 1-bit AND mask, 2 pre-multiplied alpha, 3 straight alpha), magnify in bit 3, inverse-transparent clamp in bit 4.
  - 2 and 3: position and hotspot. X in the low bits and Y from bit 16, each POS_W or HOT_W bits wide.
  - 4: size. Width-1 in the low bits and height-1 from bit 16, each SIZE_W bits wide.
  - 5 and 6: colours A and B. Blue in bits 7:0, green in 15:8, red in 23:16.
  - 7: address bits 39:32, in bits 7:0.
  - 8: address bits 31:12, in bits 31:12.
  - A read returns the pending field values in these positions, with all other bits 0.
- R3: Active outputs change only at a clock edge where frame_start_i is high and the lock is clear. A frame edge that coincides with a register write transfers the value held before that write.
- R4: While the lock is set, frame pulses leave every active output unchanged. Pending writes still complete and read back. The first frame pulse after the lock clears transfers them.
- R5: A write to offset 7 alone changes neither the readback of offsets 7 and 8 nor the address output.
- R6: A write to offset 8 makes the pending address equal to the last byte written to offset 7, then write-data bits 31:12, then 12 zero bits. Write-data bits 11:0 are ignored.
- R7: The size outputs equal the stored width-1 and height-1 plus one, from 1 to 2^SIZE_W.
- R8: While the active mode is 0 (mono), colour A outputs 0x000000 and colour B outputs 0xFFFFFF. In the other modes they output the transferred colour values.
- R9: Writes to offsets 9 to 15 change no register and read back as 0.
- R10: One accepted frame pulse transfers every field together: control, position, hotspot, size, colours and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Word offset of the register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data of the addressed register (combinational) |
| frame_start_i | input | 1 | One-cycle frame boundary pulse |
| cur_en_o | output | 1 | Active cursor enable |
| cur_mode_o | output | 2 | Active blend mode |
| cur_mag_o | output | 1 | Active 2x magnify flag |
| cur_clamp_o | output | 1 | Active inverse-transparent clamp flag |
| cur_x_o | output | POS_W | Active X position |
| cur_y_o | output | POS_W | Active Y position |
| hot_x_o | output | HOT_W | Active hotspot X |
| hot_y_o | output | HOT_W | Active hotspot Y |
| cur_w_o | output | SIZE_W+1 | Active width in pixels |
| cur_h_o | output | SIZE_W+1 | Active height in pixels |
| col_a_o | output | 24 | Active colour A after mono forcing |
| col_b_o | output | 24 | Active colour B after mono forcing |
| surf_addr_o | output | 40 | Active surface byte address |

## Verification
The bench builds the block with its default widths: 11-bit positions, 6-bit hotspot and 7-bit size fields. With these widths every stored size value can be swept, so both ends of the plus-one mapping are checked. All 32 combinations of enable, mode, magnify and clamp are driven through a frame transfer, together with the mono colour forcing each combination implies. Every offset of the 4-bit register space is written, so every unmapped offset is also covered. A reference model in the bench holds the pending and active sets. It is used to check three timing cases: lock-gated pulses, a frame pulse that lands on the same edge as a write, and staging of the split address.

// File: rtl/cursor_regbank_pkg.sv
package cursor_regbank_pkg;
  localparam int unsigned OFF_LOCK    = 0;
  localparam int unsigned OFF_CTRL    = 1;
  localparam int unsigned OFF_POS     = 2;
  localparam int unsigned OFF_HOT     = 3;
  localparam int unsigned OFF_SIZE    = 4;
  localparam int unsigned OFF_COL_A   = 5;
  localparam int unsigned OFF_COL_B   = 6;
  localparam int unsigned OFF_ADDR_HI = 7;
  localparam int unsigned OFF_ADDR_LO = 8;

  localparam int unsigned Y_LSB     = 16;
  localparam int unsigned SURF_W    = 40;
  localparam int unsigned ADDR_HI_W = 8;
  localparam int unsigned PAGE_BITS = 12;

  typedef enum logic [1:0] {
    MODE_MONO     = 2'd0,
    MODE_AND_MASK = 2'd1,
    MODE_PREMUL   = 2'd2,
    MODE_STRAIGHT = 2'd3
  } cur_mode_e;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] green;
    logic [7:0] blue;
  } rgb_t;

  typedef struct packed {
    logic      clamp;
    logic      mag;
    cur_mode_e mode;
    logic      en;
  } cur_ctrl_t;

  localparam rgb_t MONO_DARK  = '{red: 8'h00, green: 8'h00, blue: 8'h00};
  localparam rgb_t MONO_LIGHT = '{red: 8'hff, green: 8'hff, blue: 8'hff};
endpackage

// File: rtl/crb_addr_join.sv
module crb_addr_join
  import cursor_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_we_i,
  input  logic              lo_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SURF_W-1:0] pend_addr_o
);
  localparam int unsigned LO_W = SURF_W - ADDR_HI_W - PAGE_BITS;

  logic [ADDR_HI_W-1:0] stage_hi_q;
  logic [ADDR_HI_W-1:0] pend_hi_q;
  logic [LO_W-1:0]      pend_lo_q;

  // upper byte is held aside until the low word commits both halves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_hi_q <= '0;
      pend_hi_q  <= '0;
      pend_lo_q  <= '0;
    end else begin
      if (hi_we_i) stage_hi_q <= wdata_i[ADDR_HI_W-1:0];
      if (lo_we_i) begin
        pend_hi_q <= stage_hi_q;
        pend_lo_q <= wdata_i[PAGE_BITS +: LO_W];
      end
    end
  end

  assign pend_addr_o = {pend_hi_q, pend_lo_q, {PAGE_BITS{1'b0}}};

  a_r5_hi_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> $stable(pend_addr_o))
    else $error("R5: pending address moved on upper-byte write");

  a_r6_lo_takes_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> pend_addr_o[SURF_W-ADDR_HI_W-1:PAGE_BITS] == $past(wdata_i[PAGE_BITS +: LO_W]))
    else $error("R6: low word not committed");
endmodule

// File: rtl/crb_shadow.sv
module crb_shadow
  import cursor_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 4,
  parameter int unsigned POS_W  = 11,
  parameter int unsigned HOT_W  = 6,
  parameter int unsigned SIZE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lock_o,
  output cur_ctrl_t         ctrl_o,
  output logic [POS_W-1:0]  x_o,
  output logic [POS_W-1:0]  y_o,
  output logic [HOT_W-1:0]  hx_o,
  output logic [HOT_W-1:0]  hy_o,
  output logic [SIZE_W-1:0] wm1_o,
  output logic [SIZE_W-1:0] hm1_o,
  output rgb_t              col_a_o,
  output rgb_t              col_b_o,
  output logic [SURF_W-1:0] addr_o
);
  localparam int unsigned NUM_REGS = 9;
  localparam int unsigned LO_TOP   = SURF_W - ADDR_HI_W;

  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign hit[i] = we_i && (addr_i == REG_AW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o  <= 1'b0;
      ctrl_o  <= '0;
      x_o     <= '0;
      y_o     <= '0;
      hx_o    <= '0;
      hy_o    <= '0;
      wm1_o   <= '0;
      hm1_o   <= '0;
      col_a_o <= '0;
      col_b_o <= '0;
    end else begin
      if (hit[OFF_LOCK]) lock_o <= wdata_i[0];
      if (hit[OFF_CTRL]) ctrl_o <= cur_ctrl_t'(wdata_i[4:0]);
      if (hit[OFF_POS]) begin
        x_o <= wdata_i[POS_W-1:0];
        y_o <= wdata_i[Y_LSB +: POS_W];
      end
      if (hit[OFF_HOT]) begin
        hx_o <= wdata_i[HOT_W-1:0];
        hy_o <= wdata_i[Y_LSB +: HOT_W];
      end
      if (hit[OFF_SIZE]) begin
        wm1_o <= wdata_i[SIZE_W-1:0];
        hm1_o <= wdata_i[Y_LSB +: SIZE_W];
      end
      if (hit[OFF_COL_A]) col_a_o <= rgb_t'(wdata_i[23:0]);
      if (hit[OFF_COL_B]) col_b_o <= rgb_t'(wdata_i[23:0]);
    end
  end

  crb_addr_join #(.DATA_W(DATA_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hi_we_i     (hit[OFF_ADDR_HI]),
    .lo_we_i     (hit[OFF_ADDR_LO]),
    .wdata_i     (wdata_i),
    .pend_addr_o (addr_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_AW'(OFF_LOCK):    rdata_o[0] = lock_o;
      REG_AW'(OFF_CTRL):    rdata_o[4:0] = ctrl_o;
      REG_AW'(OFF_POS): begin
        rdata_o[POS_W-1:0]     = x_o;
        rdata_o[Y_LSB +: POS_W] = y_o;
      end
      REG_AW'(OFF_HOT): begin
        rdata_o[HOT_W-1:0]     = hx_o;
        rdata_o[Y_LSB +: HOT_W] = hy_o;
      end
      REG_AW'(OFF_SIZE): begin
        rdata_o[SIZE_W-1:0]     = wm1_o;
        rdata_o[Y_LSB +: SIZE_W] = hm1_o;
      end
      REG_AW'(OFF_COL_A):   rdata_o[23:0] = col_a_o;
      REG_AW'(OFF_COL_B):   rdata_o[23:0] = col_b_o;
      REG_AW'(OFF_ADDR_HI): rdata_o[ADDR_HI_W-1:0] = addr_o[SURF_W-1 -: ADDR_HI_W];
      REG_AW'(OFF_ADDR_LO): rdata_o[LO_TOP-1:0] = addr_o[LO_TOP-1:0];
      default:              rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/crb_active.sv
module crb_active
  import cursor_regbank_pkg::*;
#(
  parameter int unsigned POS_W  = 11,
  parameter int unsigned HOT_W  = 6,
  parameter int unsigned SIZE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              lock_i,
  input  cur_ctrl_t         ctrl_i,
  input  logic [POS_W-1:0]  x_i,
  input  logic [POS_W-1:0]  y_i,
  input  logic [HOT_W-1:0]  hx_i,
  input  logic [HOT_W-1:0]  hy_i,
  input  logic [SIZE_W-1:0] wm1_i,
  input  logic [SIZE_W-1:0] hm1_i,
  input  rgb_t              col_a_i,
  input  rgb_t              col_b_i,
  input  logic [SURF_W-1:0] addr_i,
  output cur_ctrl_t         ctrl_o,
  output logic [POS_W-1:0]  x_o,
  output logic [POS_W-1:0]  y_o,
  output logic [HOT_W-1:0]  hx_o,
  output logic [HOT_W-1:0]  hy_o,
  output logic [SIZE_W:0]   w_o,
  output logic [SIZE_W:0]   h_o,
  output rgb_t              col_a_o,
  output rgb_t              col_b_o,
  output logic [SURF_W-1:0] addr_o
);
  logic              take;
  logic [SIZE_W-1:0] wm1_q, hm1_q;
  rgb_t              col_a_q, col_b_q;
  logic              mono;

  assign take = frame_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      x_o     <= '0;
      y_o     <= '0;
      hx_o    <= '0;
      hy_o    <= '0;
      wm1_q   <= '0;
      hm1_q   <= '0;
      col_a_q <= '0;
      col_b_q <= '0;
      addr_o  <= '0;
    end else if (take) begin
      ctrl_o  <= ctrl_i;
      x_o     <= x_i;
      y_o     <= y_i;
      hx_o    <= hx_i;
      hy_o    <= hy_i;
      wm1_q   <= wm1_i;
      hm1_q   <= hm1_i;
      col_a_q <= col_a_i;
      col_b_q <= col_b_i;
      addr_o  <= addr_i;
    end
  end

  // stored size is one less than the pixel count
  assign w_o = {1'b0, wm1_q} + 1'b1;
  assign h_o = {1'b0, hm1_q} + 1'b1;

  assign mono    = (ctrl_o.mode == MODE_MONO);
  assign col_a_o = mono ? MONO_DARK  : col_a_q;
  assign col_b_o = mono ? MONO_LIGHT : col_b_q;

  a_r4_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable({ctrl_o, x_o, y_o, hx_o, hy_o, w_o, h_o, addr_o}))
    else $error("R4: active state moved while locked");

  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable({ctrl_o, x_o, y_o, hx_o, hy_o, w_o, h_o, addr_o}))
    else $error("R3: active state moved without frame pulse");

  a_r10_joint_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !lock_i) |=> (x_o == $past(x_i) && hy_o == $past(hy_i) &&
                              ctrl_o == $past(ctrl_i) && addr_o == $past(addr_i)))
    else $error("R10: fields not copied together");
endmodule

// File: rtl/cursor_regbank.sv
module cursor_regbank
  import cursor_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 4,
  parameter int unsigned POS_W  = 11,
  parameter int unsigned HOT_W  = 6,
  parameter int unsigned SIZE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              frame_start_i,
  output logic              cur_en_o,
  output logic [1:0]        cur_mode_o,
  output logic              cur_mag_o,
  output logic              cur_clamp_o,
  output logic [POS_W-1:0]  cur_x_o,
  output logic [POS_W-1:0]  cur_y_o,
  output logic [HOT_W-1:0]  hot_x_o,
  output logic [HOT_W-1:0]  hot_y_o,
  output logic [SIZE_W:0]   cur_w_o,
  output logic [SIZE_W:0]   cur_h_o,
  output logic [23:0]       col_a_o,
  output logic [23:0]       col_b_o,
  output logic [SURF_W-1:0] surf_addr_o
);
  logic              sh_lock;
  cur_ctrl_t         sh_ctrl, act_ctrl;
  logic [POS_W-1:0]  sh_x, sh_y;
  logic [HOT_W-1:0]  sh_hx, sh_hy;
  logic [SIZE_W-1:0] sh_wm1, sh_hm1;
  rgb_t              sh_col_a, sh_col_b, act_col_a, act_col_b;
  logic [SURF_W-1:0] sh_addr;

  crb_shadow #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .POS_W(POS_W), .HOT_W(HOT_W), .SIZE_W(SIZE_W)
  ) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .lock_o  (sh_lock),
    .ctrl_o  (sh_ctrl),
    .x_o     (sh_x),
    .y_o     (sh_y),
    .hx_o    (sh_hx),
    .hy_o    (sh_hy),
    .wm1_o   (sh_wm1),
    .hm1_o   (sh_hm1),
    .col_a_o (sh_col_a),
    .col_b_o (sh_col_b),
    .addr_o  (sh_addr)
  );

  crb_active #(
    .POS_W(POS_W), .HOT_W(HOT_W), .SIZE_W(SIZE_W)
  ) u_active (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_start_i),
    .lock_i  (sh_lock),
    .ctrl_i  (sh_ctrl),
    .x_i     (sh_x),
    .y_i     (sh_y),
    .hx_i    (sh_hx),
    .hy_i    (sh_hy),
    .wm1_i   (sh_wm1),
    .hm1_i   (sh_hm1),
    .col_a_i (sh_col_a),
    .col_b_i (sh_col_b),
    .addr_i  (sh_addr),
    .ctrl_o  (act_ctrl),
    .x_o     (cur_x_o),
    .y_o     (cur_y_o),
    .hx_o    (hot_x_o),
    .hy_o    (hot_y_o),
    .w_o     (cur_w_o),
    .h_o     (cur_h_o),
    .col_a_o (act_col_a),
    .col_b_o (act_col_b),
    .addr_o  (surf_addr_o)
  );

  assign cur_en_o    = act_ctrl.en;
  assign cur_mode_o  = act_ctrl.mode;
  assign cur_mag_o   = act_ctrl.mag;
  assign cur_clamp_o = act_ctrl.clamp;
  assign col_a_o     = act_col_a;
  assign col_b_o     = act_col_b;
endmodule

// File: tb/cursor_regbank_test.sv
module cursor_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int POS_W = 11, HOT_W = 6, SIZE_W = 7;

  logic        clk = 0, rst_n = 0, we = 0, frame = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        en_o, mag_o, clamp_o;
  logic [1:0]  mode_o;
  logic [POS_W-1:0]  x_o, y_o;
  logic [HOT_W-1:0]  hx_o, hy_o;
  logic [SIZE_W:0]   w_o, h_o;
  logic [23:0] ca_o, cb_o;
  logic [39:0] sa_o;

  int checks = 0, fails = 0;

  // reference model: pending (p_) and active (a_) sets
  logic p_lock;
  logic [4:0]  p_ctrl, a_ctrl;
  logic [POS_W-1:0] p_x, p_y, a_x, a_y;
  logic [HOT_W-1:0] p_hx, p_hy, a_hx, a_hy;
  logic [SIZE_W-1:0] p_w, p_h, a_w, a_h;
  logic [23:0] p_ca, p_cb, a_ca, a_cb;
  logic [7:0]  stage_hi, p_hi;
  logic [19:0] p_lo;
  logic [39:0] a_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .frame_start_i(frame),
    .cur_en_o(en_o), .cur_mode_o(mode_o), .cur_mag_o(mag_o), .cur_clamp_o(clamp_o),
    .cur_x_o(x_o), .cur_y_o(y_o), .hot_x_o(hx_o), .hot_y_o(hy_o),
    .cur_w_o(w_o), .cur_h_o(h_o), .col_a_o(ca_o), .col_b_o(cb_o), .surf_addr_o(sa_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    p_lock = 0; p_ctrl = 0; a_ctrl = 0; p_x = 0; p_y = 0; a_x = 0; a_y = 0;
    p_hx = 0; p_hy = 0; a_hx = 0; a_hy = 0; p_w = 0; p_h = 0; a_w = 0; a_h = 0;
    p_ca = 0; p_cb = 0; a_ca = 0; a_cb = 0; stage_hi = 0; p_hi = 0; p_lo = 0; a_addr = 0;
  endtask

  task automatic model_take();
    if (!p_lock) begin
      a_ctrl = p_ctrl; a_x = p_x; a_y = p_y; a_hx = p_hx; a_hy = p_hy;
      a_w = p_w; a_h = p_h; a_ca = p_ca; a_cb = p_cb; a_addr = {p_hi, p_lo, 12'h000};
    end
  endtask

  task automatic model_write(input int off, input logic [31:0] d);
    case (off)
      0: p_lock = d[0];
      1: p_ctrl = d[4:0];
      2: begin p_x = d[POS_W-1:0]; p_y = d[16 +: POS_W]; end
      3: begin p_hx = d[HOT_W-1:0]; p_hy = d[16 +: HOT_W]; end
      4: begin p_w = d[SIZE_W-1:0]; p_h = d[16 +: SIZE_W]; end
      5: p_ca = d[23:0];
      6: p_cb = d[23:0];
      7: stage_hi = d[7:0];
      8: begin p_hi = stage_hi; p_lo = d[31:12]; end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_read(input int off);
    logic [31:0] r = '0;
    case (off)
      0: r[0] = p_lock;
      1: r[4:0] = p_ctrl;
      2: begin r[POS_W-1:0] = p_x; r[16 +: POS_W] = p_y; end
      3: begin r[HOT_W-1:0] = p_hx; r[16 +: HOT_W] = p_hy; end
      4: begin r[SIZE_W-1:0] = p_w; r[16 +: SIZE_W] = p_h; end
      5: r[23:0] = p_ca;
      6: r[23:0] = p_cb;
      7: r[7:0] = p_hi;
      8: r = {p_lo, 12'h000};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk); we = 1; addr = 4'(off); wdata = d;
    @(negedge clk); we = 0;
    model_write(off, d);
  endtask

  task automatic pulse();
    @(negedge clk); frame = 1;
    @(negedge clk); frame = 0;
    model_take();
  endtask

  // write and frame pulse on the same edge: active takes the older pending value
  task automatic wr_pulse(input int off, input logic [31:0] d);
    @(negedge clk); we = 1; frame = 1; addr = 4'(off); wdata = d;
    @(negedge clk); we = 0; frame = 0;
    model_take();
    model_write(off, d);
  endtask

  task automatic rd_chk(input string req, input int off);
    @(negedge clk); addr = 4'(off); #1;
    chk(req, 64'(rdata), 64'(exp_read(off)));
  endtask

  task automatic out_chk(input string req);
    logic [1:0] m = a_ctrl[2:1];
    #1;
    chk({req, " en"}, 64'(en_o), 64'(a_ctrl[0]));
    chk({req, " mode"}, 64'(mode_o), 64'(m));
    chk({req, " mag"}, 64'(mag_o), 64'(a_ctrl[3]));
    chk({req, " clamp"}, 64'(clamp_o), 64'(a_ctrl[4]));
    chk({req, " pos"}, 64'({x_o, y_o}), 64'({a_x, a_y}));
    chk({req, " hot"}, 64'({hx_o, hy_o}), 64'({a_hx, a_hy}));
    chk({req, " width"}, 64'(w_o), 64'(a_w) + 64'd1);
    chk({req, " height"}, 64'(h_o), 64'(a_h) + 64'd1);
    chk({req, " colA"}, 64'(ca_o), (m == 2'd0) ? 64'h0 : 64'(a_ca));
    chk({req, " colB"}, 64'(cb_o), (m == 2'd0) ? 64'hffffff : 64'(a_cb));
    chk({req, " addr"}, 64'(sa_o), 64'(a_addr));
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    out_chk("R1");
    for (int o = 0; o < 16; o++) rd_chk("R1 read", o);

    // R2: all-ones writes read back only defined fields
    for (int o = 1; o < 9; o++) wr(o, 32'hffff_ffff);
    for (int o = 0; o < 9; o++) rd_chk("R2", o);
    // R3: no frame yet, outputs still at reset values
    out_chk("R3 idle");
    // R10: one pulse moves every field
    pulse();
    out_chk("R10");

    // R8 and R2 control layout: sweep all control combinations
    wr(5, 32'h00a1b2c3); wr(6, 32'h00102030);
    for (int c = 0; c < 32; c++) begin
      wr(1, 32'(c));
      rd_chk("R2 ctrl", 1);
      pulse();
      out_chk("R8");
    end

    // R7: exhaustive size sweep
    for (int s = 0; s < (1 << SIZE_W); s++) begin
      wr(4, {16'(((1 << SIZE_W) - 1) - s), 16'(s)});
      pulse();
      out_chk("R7");
    end

    // R4: lock holds the active set
    wr(0, 32'h1);
    wr(2, {16'd1234, 16'd567});
    wr(3, {16'd9, 16'd33});
    pulse(); pulse();
    out_chk("R4 locked");
    rd_chk("R4 pending", 2);
    rd_chk("R4 lockbit", 0);
    wr(0, 32'h0);
    out_chk("R3 unlocked no pulse");
    pulse();
    out_chk("R4 released");

    // R5/R6: split address
    wr(7, 32'h0000_00ab);
    rd_chk("R5 hi", 7);
    rd_chk("R5 lo", 8);
    pulse();
    out_chk("R5 out");
    wr(7, 32'h0000_0055);
    wr(8, 32'h1234_5fff);
    rd_chk("R6 hi", 7);
    rd_chk("R6 lo", 8);
    pulse();
    chk("R6 addr", 64'(sa_o), 64'h55_1234_5000);
    wr(8, 32'hfedc_b000);
    pulse();
    chk("R6 hi reuse", 64'(sa_o), 64'h55_fedc_b000);

    // R3: frame coinciding with write uses old value
    wr_pulse(2, {16'd7, 16'd8});
    out_chk("R3 same edge");
    pulse();
    out_chk("R3 next frame");

    // R9: unmapped offsets
    for (int o = 9; o < 16; o++) wr(o, 32'hffff_ffff);
    for (int o = 0; o < 16; o++) rd_chk("R9", o);
    pulse();
    out_chk("R9 out");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule